// File: doc/BRIEF.md
# Dual-Timer System Control Register Block

This block is a word-addressed control peripheral on a 32-bit register bus. It carries two identical up-counting timers. Each timer has a control word, a compare word and a counter word, and each drives its own interrupt line. Alongside the timers sit a small set of registers:

- a strapping input word;
- a scratch word for debug use;
- three read-only identity words: system ID, clock rate and capability mask;
- a reconfiguration command word that reports ready;
- a reset-request word.

Software reads and writes these through a single-cycle bus with byte enables. Only full-word accesses are accepted.

Each timer is run by a two-state machine:

- **TM_STOP**: the counter holds its value.
- **TM_RUN**: the counter advances by one on every clock.

The transitions are:

- **START** (TM_STOP to TM_RUN): a control write with the enable bit set.
- **HALT** (TM_RUN to TM_STOP): a control write with the enable bit clear.
- **EXPIRE** (TM_RUN to TM_STOP): a compare match while auto-restart is clear.
- **WRAP** (TM_RUN to TM_RUN): a compare match while auto-restart is set; the counter returns to zero.

Every match produces a one-cycle interrupt pulse. Illegal accesses are dropped and reported on a one-cycle error pulse. A write to the reset-request word produces a reset-request pulse. A shutdown command written to the reconfiguration word produces a shutdown pulse.

Top module: `sct_sysctrl`

## Requirements
- R1: While a timer is in TM_RUN and its counter differs from its compare value, the counter rises by exactly 1 per clock. A read of the counter word returns the live value in the same cycle, and a direct write to the counter or compare word takes effect at the next edge.
- R2: In a timer's control word, bit 0 is enable and bit 1 is auto-restart. A read returns {auto-restart, enable} in bits 1:0 with zeros above. The word map for timer t (t = 0 or 1) is: control at word 4+4t, compare at word 5+4t, counter at word 6+4t.
- R3: On a match with auto-restart clear (EXPIRE), the enable bit reads back 0 and the counter holds at the compare value. Starting from counter 0 and compare K, the interrupt is first seen K+1 clocks after the edge that wrote enable.
- R4: Each match drives a single-cycle pulse on that timer's own bit of `tmr_irq`, in the cycle after the match cycle. The other timer's bit stays low.
- R5: On a match with auto-restart set (WRAP), the counter reloads to 0 and keeps counting, so interrupt pulses repeat every compare+1 clocks.
- R6: The following accesses change no state and raise `access_err` for one cycle after the access; a read of an unmapped word also returns 0:
  - a write to the system ID (word 24), clock rate (word 25), capability (word 26) or strapping (word 0) word;
  - any access to an unmapped word;
  - any access whose byte enables are not all set.
- R7: After reset, both timers are in TM_STOP with control, compare and counter all 0, and the scratch word is 0. Word 0 reads the STRAP parameter, word 24 reads SYSID (default 0x10014D31), word 25 reads CLK_HZ, word 26 reads CAPS (default 0), and the reconfiguration word (word 16) reads 1 (ready).
- R8: The scratch word at word 20 stores any full 32-bit value and reads it back.
- R9: A write to the reset-request word (word 17) produces a one-cycle `sys_reset_pulse` after the write. No other access raises it.
- R10: A write to word 16 whose low 16 bits equal SHUTDOWN_CMD (default 0x000E) produces a one-cycle `shutdown_pulse`. Other values produce no pulse, and word 16 keeps reading ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; timers advance on every rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe for one cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_be | input | DW/8 | Byte enables; must be all ones |
| bus_addr | input | AW | Word index |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid in the access cycle |
| tmr_irq | output | 2 | Per-timer match pulse |
| sys_reset_pulse | output | 1 | System reset request pulse |
| shutdown_pulse | output | 1 | Shutdown request pulse |
| access_err | output | 1 | Illegal-access pulse |

## Verification
The bench builds the block with CAPS = 0x5A5A0001, STRAP = 3 and CLK_HZ = 50000000, so that every identity word reads back a distinct non-zero value and a wrong decode cannot go unnoticed. Under that configuration the bench covers three sweeps:
- every one of the 32 word indices, on both read and write, against a computed map of legal, read-only and unmapped words;
- one-shot delays for compare values 0 to 6 on both timers, each checked against K+1;
- auto-restart periods for compare values 1 to 5, each checked against compare+1.

// File: rtl/sct_pkg.sv
package sct_pkg;
    localparam int unsigned NTMR       = 2;
    localparam int unsigned TMR_BASE   = 4;
    localparam int unsigned TMR_STRIDE = 4;
    localparam int unsigned OFS_CTL    = 0;
    localparam int unsigned OFS_CMP    = 1;
    localparam int unsigned OFS_CNT    = 2;
    localparam int unsigned BIT_EN     = 0;
    localparam int unsigned BIT_AR     = 1;

    typedef enum logic {
        TM_STOP = 1'b0,
        TM_RUN  = 1'b1
    } tm_state_e;

    typedef enum logic [4:0] {
        RG_STRAP   = 5'd0,
        RG_RECONF  = 5'd16,
        RG_RESET   = 5'd17,
        RG_SCRATCH = 5'd20,
        RG_SYSID   = 5'd24,
        RG_CLKHZ   = 5'd25,
        RG_CAPS    = 5'd26
    } misc_reg_e;
endpackage

// File: rtl/sct_decode.sv
module sct_decode
    import sct_pkg::*;
#(
    parameter int unsigned AW  = 5,
    parameter int unsigned BEW = 4
) (
    input  logic            sel,
    input  logic            we,
    input  logic [BEW-1:0]  be,
    input  logic [AW-1:0]   addr,
    output logic [NTMR-1:0] ctl_we,
    output logic [NTMR-1:0] cmp_we,
    output logic [NTMR-1:0] cnt_we,
    output logic            scr_we,
    output logic            rst_hit,
    output logic            cfg_we,
    output logic            illegal
);
    logic mapped, rdonly, wr_ok, tmr_hit;

    always_comb begin
        tmr_hit = 1'b0;
        mapped  = 1'b1;
        rdonly  = 1'b0;
        scr_we  = 1'b0;
        rst_hit = 1'b0;
        cfg_we  = 1'b0;
        ctl_we  = '0;
        cmp_we  = '0;
        cnt_we  = '0;
        wr_ok   = sel && we && (be == {BEW{1'b1}});
        for (int t = 0; t < NTMR; t++) begin
            if (addr == AW'(TMR_BASE + TMR_STRIDE*t + OFS_CTL)) begin
                tmr_hit = 1'b1; ctl_we[t] = wr_ok;
            end
            if (addr == AW'(TMR_BASE + TMR_STRIDE*t + OFS_CMP)) begin
                tmr_hit = 1'b1; cmp_we[t] = wr_ok;
            end
            if (addr == AW'(TMR_BASE + TMR_STRIDE*t + OFS_CNT)) begin
                tmr_hit = 1'b1; cnt_we[t] = wr_ok;
            end
        end
        case (addr)
            RG_STRAP, RG_SYSID, RG_CLKHZ, RG_CAPS: rdonly = 1'b1;
            RG_RECONF:  cfg_we  = wr_ok;
            RG_RESET:   rst_hit = wr_ok;
            RG_SCRATCH: scr_we  = wr_ok;
            default:    mapped  = tmr_hit;
        endcase
        illegal = sel && ((be != {BEW{1'b1}}) || !mapped || (we && rdonly));
    end
endmodule

// File: rtl/sct_timer.sv
module sct_timer
    import sct_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_we,
    input  logic          cmp_we,
    input  logic          cnt_we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] cnt,
    output logic [DW-1:0] cmp,
    output logic          run,
    output logic          auto,
    output logic          irq
);
    tm_state_e     state_q, state_d;
    logic          ar_q, irq_q, match;
    logic [DW-1:0] cnt_q, cmp_q, cnt_d;

    assign match = (state_q == TM_RUN) && (cnt_q == cmp_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TM_STOP: if (ctl_we && wdata[BIT_EN]) state_d = TM_RUN;      // START
            TM_RUN: begin
                if (ctl_we)               state_d = wdata[BIT_EN] ? TM_RUN : TM_STOP; // HALT
                else if (match && !ar_q)  state_d = TM_STOP;             // EXPIRE
            end
        endcase
        if (cnt_we)                  cnt_d = wdata;
        else if (match)              cnt_d = ar_q ? '0 : cnt_q;         // WRAP or hold
        else if (state_q == TM_RUN)  cnt_d = cnt_q + 1'b1;
        else                         cnt_d = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TM_STOP;
            ar_q    <= 1'b0;
            cnt_q   <= '0;
            cmp_q   <= '0;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            irq_q   <= match;
            if (ctl_we) ar_q  <= wdata[BIT_AR];
            if (cmp_we) cmp_q <= wdata;
        end
    end

    always_comb begin
        cnt  = cnt_q;
        cmp  = cmp_q;
        run  = (state_q == TM_RUN);
        auto = ar_q;
        irq  = irq_q;
    end
endmodule

// File: rtl/sct_sysctrl.sv
module sct_sysctrl
    import sct_pkg::*;
#(
    parameter int unsigned DW           = 32,
    parameter int unsigned AW           = 5,
    parameter logic [31:0] SYSID        = 32'h10014D31,
    parameter logic [31:0] CLK_HZ       = 32'd50000000,
    parameter logic [31:0] CAPS         = 32'h0,
    parameter logic [31:0] STRAP        = 32'h1,
    parameter logic [15:0] SHUTDOWN_CMD = 16'h000E
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_sel,
    input  logic            bus_we,
    input  logic [DW/8-1:0] bus_be,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    output logic [NTMR-1:0] tmr_irq,
    output logic            sys_reset_pulse,
    output logic            shutdown_pulse,
    output logic            access_err
);
    localparam int unsigned BEW = DW / 8;

    logic [NTMR-1:0][DW-1:0] t_cnt, t_cmp;
    logic [NTMR-1:0]         t_run, t_auto, ctl_we, cmp_we, cnt_we;
    logic                    scr_we, rst_hit, cfg_we, illegal;
    logic [DW-1:0]           scratch_q;
    logic                    rst_q, shd_q, err_q;

    sct_decode #(.AW(AW), .BEW(BEW)) u_dec (
        .sel(bus_sel), .we(bus_we), .be(bus_be), .addr(bus_addr),
        .ctl_we(ctl_we), .cmp_we(cmp_we), .cnt_we(cnt_we),
        .scr_we(scr_we), .rst_hit(rst_hit), .cfg_we(cfg_we), .illegal(illegal)
    );

    for (genvar g = 0; g < NTMR; g++) begin : g_tmr
        sct_timer #(.DW(DW)) u_tmr (
            .clk(clk), .rst_n(rst_n),
            .ctl_we(ctl_we[g]), .cmp_we(cmp_we[g]), .cnt_we(cnt_we[g]),
            .wdata(bus_wdata),
            .cnt(t_cnt[g]), .cmp(t_cmp[g]), .run(t_run[g]), .auto(t_auto[g]),
            .irq(tmr_irq[g])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scratch_q <= '0;
            rst_q     <= 1'b0;
            shd_q     <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            if (scr_we) scratch_q <= bus_wdata;
            rst_q <= rst_hit;
            shd_q <= cfg_we && (bus_wdata[15:0] == SHUTDOWN_CMD);
            err_q <= illegal;
        end
    end

    always_comb begin
        logic tmr_sel;
        tmr_sel   = 1'b0;
        bus_rdata = '0;
        for (int t = 0; t < NTMR; t++) begin
            if (bus_addr == AW'(TMR_BASE + TMR_STRIDE*t + OFS_CTL)) begin
                tmr_sel = 1'b1; bus_rdata = DW'({t_auto[t], t_run[t]});
            end
            if (bus_addr == AW'(TMR_BASE + TMR_STRIDE*t + OFS_CMP)) begin
                tmr_sel = 1'b1; bus_rdata = t_cmp[t];
            end
            if (bus_addr == AW'(TMR_BASE + TMR_STRIDE*t + OFS_CNT)) begin
                tmr_sel = 1'b1; bus_rdata = t_cnt[t];
            end
        end
        if (!tmr_sel) begin
            case (bus_addr)
                RG_STRAP:   bus_rdata = DW'(STRAP);
                RG_RECONF:  bus_rdata = DW'(1);
                RG_SCRATCH: bus_rdata = scratch_q;
                RG_SYSID:   bus_rdata = DW'(SYSID);
                RG_CLKHZ:   bus_rdata = DW'(CLK_HZ);
                RG_CAPS:    bus_rdata = DW'(CAPS);
                default:    bus_rdata = '0;
            endcase
        end
    end

    always_comb begin
        sys_reset_pulse = rst_q;
        shutdown_pulse  = shd_q;
        access_err      = err_q;
    end
endmodule

// File: rtl/sct_sysctrl_chk.sv
module sct_sysctrl_chk
    import sct_pkg::*;
#(
    parameter int unsigned DW = 32,
    parameter int unsigned AW = 5
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    bus_sel,
    input logic                    bus_we,
    input logic [AW-1:0]           bus_addr,
    input logic [NTMR-1:0][DW-1:0] t_cnt,
    input logic [NTMR-1:0][DW-1:0] t_cmp,
    input logic [NTMR-1:0]         t_run,
    input logic [NTMR-1:0]         t_auto,
    input logic [NTMR-1:0]         cnt_we,
    input logic [NTMR-1:0]         ctl_we,
    input logic [NTMR-1:0]         tmr_irq,
    input logic                    access_err,
    input logic                    sys_reset_pulse
);
    for (genvar g = 0; g < NTMR; g++) begin : g_chk
        p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (t_run[g] && t_cnt[g] != t_cmp[g] && !cnt_we[g])
            |=> t_cnt[g] == $past(t_cnt[g]) + 1'b1);
        p_oneshot_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (t_run[g] && t_cnt[g] == t_cmp[g] && !t_auto[g] && !ctl_we[g] && !cnt_we[g])
            |=> (!t_run[g] && t_cnt[g] == $past(t_cnt[g])));
        p_irq_from_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
            tmr_irq[g] |-> $past(t_run[g] && t_cnt[g] == t_cmp[g]));
        p_wrap_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (t_run[g] && t_cnt[g] == t_cmp[g] && t_auto[g] && !ctl_we[g] && !cnt_we[g])
            |=> (t_run[g] && t_cnt[g] == '0));
    end

    p_err_from_access_r6: assert property (@(posedge clk) disable iff (!rst_n)
        access_err |-> $past(bus_sel));
    p_reset_from_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_pulse |-> $past(bus_sel && bus_we && bus_addr == AW'(RG_RESET)));
endmodule

bind sct_sysctrl sct_sysctrl_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .t_cnt(t_cnt), .t_cmp(t_cmp), .t_run(t_run),
    .t_auto(t_auto), .cnt_we(cnt_we), .ctl_we(ctl_we), .tmr_irq(tmr_irq),
    .access_err(access_err), .sys_reset_pulse(sys_reset_pulse)
);

// File: tb/sct_sysctrl_bench.sv
`timescale 1ns/1ps
module sct_sysctrl_bench;
    localparam logic [31:0] B_SYSID = 32'h10014D31;
    localparam logic [31:0] B_HZ    = 32'd50000000;
    localparam logic [31:0] B_CAPS  = 32'h5A5A0001;
    localparam logic [31:0] B_STRAP = 32'h3;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [3:0]  bus_be = 4'hF;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [1:0]  tmr_irq;
    logic        sys_reset_pulse, shutdown_pulse, access_err;
    int          total = 0, bad = 0;

    always #10 clk = ~clk;

    sct_sysctrl #(.SYSID(B_SYSID), .CLK_HZ(B_HZ), .CAPS(B_CAPS), .STRAP(B_STRAP)) u_sct_sysctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_be(bus_be),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tmr_irq(tmr_irq), .sys_reset_pulse(sys_reset_pulse),
        .shutdown_pulse(shutdown_pulse), .access_err(access_err));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; bus_be = 4'hF;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d, output logic e);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        e = access_err;
        bus_sel = 1'b0;
    endtask

    function automatic logic [31:0] rst_val(input int a);
        case (a)
            0: return B_STRAP;   16: return 32'd1;
            24: return B_SYSID;  25: return B_HZ;  26: return B_CAPS;
            default: return 32'd0;
        endcase
    endfunction

    function automatic bit is_mapped(input int a);
        return (a == 0) || (a >= 4 && a <= 6) || (a >= 8 && a <= 10) ||
               a == 16 || a == 17 || a == 20 || (a >= 24 && a <= 26);
    endfunction

    function automatic bit is_ro(input int a);
        return a == 0 || (a >= 24 && a <= 26);
    endfunction

    initial begin
        #(200000 * 20);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d, d2;
        logic        e;
        int          n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R7 reset state across the whole map; R6 unmapped reads flag and return 0
        for (int a = 0; a < 32; a++) begin
            rd(5'(a), d, e);
            chk("R7 reset value", d, rst_val(a));
            chk("R6 read flag", {31'd0, e}, {31'd0, !is_mapped(a)});
        end
        chk("R7 irq idle", {30'd0, tmr_irq}, 32'd0);

        // R6 / R9 write sweep of zero to every word
        for (int a = 0; a < 32; a++) begin
            wr(5'(a), 32'd0);
            chk("R6 write flag", {31'd0, access_err}, {31'd0, !is_mapped(a) || is_ro(a)});
            chk("R9 reset pulse", {31'd0, sys_reset_pulse}, {31'd0, a == 17});
            chk("R10 no shutdown", {31'd0, shutdown_pulse}, 32'd0);
        end
        @(negedge clk);
        chk("R9 pulse single", {31'd0, sys_reset_pulse}, 32'd0);
        for (int a = 0; a < 32; a++) begin
            if (is_ro(a)) begin
                wr(5'(a), 32'hFFFF_FFFF);
                rd(5'(a), d, e);
                chk("R6 read-only unchanged", d, rst_val(a));
            end
        end

        // R8 scratchpad, R6 partial byte enables
        wr(5'd20, 32'hDEADBEEF);
        chk("R8 no error", {31'd0, access_err}, 32'd0);
        rd(5'd20, d, e);
        chk("R8 readback", d, 32'hDEADBEEF);
        wr(5'd20, 32'h12345678, 4'b0011);
        chk("R6 partial flag", {31'd0, access_err}, 32'd1);
        rd(5'd20, d, e);
        chk("R6 partial ignored", d, 32'hDEADBEEF);

        // R10 shutdown command decode
        wr(5'd16, 32'h1234000E);
        chk("R10 shutdown pulse", {31'd0, shutdown_pulse}, 32'd1);
        wr(5'd16, 32'h0000000F);
        chk("R10 other cmd", {31'd0, shutdown_pulse}, 32'd0);
        rd(5'd16, d, e);
        chk("R10 still ready", d, 32'd1);

        for (int t = 0; t < 2; t++) begin
            logic [4:0] c_ctl, c_cmp, c_cnt;
            c_ctl = 5'(4 + 4*t); c_cmp = 5'(5 + 4*t); c_cnt = 5'(6 + 4*t);

            // R2 control readback without enable
            wr(c_ctl, 32'h2);
            rd(c_ctl, d, e);
            chk("R2 ctl readback", d, 32'h2);
            rd(c_cnt, d, e);
            chk("R2 stopped counter", d, 32'd0);
            wr(c_ctl, 32'h0);

            // R3 / R4 one-shot sweep
            for (int k = 0; k <= 6; k++) begin
                wr(c_cnt, 32'd0);
                wr(c_cmp, 32'(k));
                wr(c_ctl, 32'h1);
                n = 0;
                for (int i = 1; i <= 20 && n == 0; i++) begin
                    @(negedge clk);
                    if (tmr_irq[t]) n = i;
                    chk("R4 other irq quiet", {31'd0, tmr_irq[1-t]}, 32'd0);
                end
                chk("R3 one-shot delay", 32'(n), 32'(k + 1));
                @(negedge clk);
                chk("R4 single pulse", {31'd0, tmr_irq[t]}, 32'd0);
                rd(c_ctl, d, e);
                chk("R3 enable cleared", d, 32'd0);
                rd(c_cnt, d, e);
                chk("R3 counter holds", d, 32'(k));
            end

            // R5 auto-restart period sweep
            for (int k = 1; k <= 5; k++) begin
                wr(c_cnt, 32'd0);
                wr(c_cmp, 32'(k));
                wr(c_ctl, 32'h3);
                while (!tmr_irq[t]) @(negedge clk);
                for (int rep = 0; rep < 2; rep++) begin
                    n = 0;
                    for (int i = 1; i <= 20 && n == 0; i++) begin
                        @(negedge clk);
                        if (tmr_irq[t]) n = i;
                    end
                    chk("R5 period", 32'(n), 32'(k + 1));
                end
                rd(c_ctl, d, e);
                chk("R5 stays enabled", d, 32'h3);
                wr(c_ctl, 32'h0);
            end

            // R1 live counting and direct counter write
            wr(c_cmp, 32'hFFFF_0000);
            wr(c_cnt, 32'd100);
            wr(c_ctl, 32'h1);
            rd(c_cnt, d, e);
            repeat (5) @(negedge clk);
            rd(c_cnt, d2, e);
            chk("R1 live step", d2 - d, 32'd6);
            wr(c_ctl, 32'h0);
            rd(c_cnt, d, e);
            @(negedge clk);
            rd(c_cnt, d2, e);
            chk("R1 halted holds", d2, d);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule